// File: doc/BRIEF.md
# Multi-channel ADC output pattern formatter

This block feeds the per-channel serializers of an eight-lane, 12-bit converter output. A bit counter splits time into frames of twelve clock cycles. On the last cycle of each frame, every lane loads a new 12-bit word. In normal mode the word is that lane's live sample. In test mode every lane carries the same pattern word, drawn from one of six generators: alternating skew, sync, a two-frame custom word, a ramp, and two pseudorandom sequences.

Before a word is loaded it passes through the output coding stage. This stage can switch it from offset binary to two's complement, and it sets whether the word is sent LSB-first or MSB-first. The serial lanes, the frame marker and the bit-clock marker can each be held at a static level instead of running. A byte-wide write port sets the control fields and the three custom bytes.

Top module: `adc_pattern_fmt`

## Requirements
- R1: After reset the block is in normal mode with offset-binary coding, LSB-first order, no level overrides and all custom bytes zero, and every lane holds zero. The frame marker is high in bit slots 0 to 5 and low in slots 6 to 11. The bit-clock marker is high in even slots and low in odd slots.
- R2: Each frame lasts 12 cycles. Lane c emits one word per frame, one bit per cycle, starting in slot 0. The word is captured at the clock edge that ends slot 11. In normal mode the word is bits [12c+11:12c] of `sample_i`, and the pattern select has no effect.
- R3: A write with `wr_en_i` high updates one register at the clock edge:
  - address 1 holds test enable in bit 0 and the pattern select in bits 3:1;
  - address 2 holds two's complement in bit 0 and MSB-first in bit 1;
  - address 3 holds the data level in bits 1:0, the frame level in bits 3:2 and the clock level in bits 5:4;
  - addresses 7, 8 and 9 are the custom bytes;
  - other addresses are ignored.
- R4: Pattern select 0 sends 0x555 on every frame and select 1 sends 0xFC0 on every frame, identically on all lanes.
- R5: Pattern select 2 forms the 24-bit value {byte 7, byte 8, byte 9}. Bits 23:12 go out on the first test frame and on every second frame after it. Bits 11:0 go out on the frames in between.
- R6: Pattern select 3 sends a count that starts at 0 on the first test frame, rises by 1 per frame, and wraps from 4095 to 0.
- R7: Pattern select 4 is a 9-bit shift sequence. The state is all ones whenever test mode is off. Each frame takes 12 steps. Each step forms the bit s[8]^s[4], shifts it into s[0] and stores it as the next word bit, starting at bit 0. The sequence also advances during test frames that show a different pattern.
- R8: Pattern select 5 works the same way as R7, with a 23-bit state, step bit s[22]^s[17] and a seed of all ones.
- R9: Two's-complement coding inverts bit 11 of the word from any source before it is serialized.
- R10: With MSB-first set, a word goes out from bit 11 down to bit 0. Otherwise it goes out from bit 0 up to bit 11.
- R11: The data level field works as follows: 10 forces every lane low, 11 forces every lane high, and 0x lets the lanes run. The field acts only in normal mode; in test mode the pattern is always sent.
- R12: The frame and clock level fields use the same coding as R11 and act in both modes, from the cycle after the write.
- R13: Pattern selects 6 and 7 send an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| sample_i | input | 96 | Live samples, 12 bits per lane, lane 0 in the low bits |
| ser_o | output | 8 | Serial data, one bit per lane |
| frame_o | output | 1 | Frame marker |
| dclk_o | output | 1 | Bit-clock marker |

## Verification
A wrong slot count shifts the frame marker and misaligns every lane's word within one frame. A sequence generator that is mis-seeded, or that steps on the wrong edge, shows a wrong word in the very first test frame, or in the frame that follows a pattern switch. A parity bit that is off by one swaps the two custom halves, which is visible by the second test frame. A ramp wrap fault stays hidden until 4096 frames have passed, so the ramp is driven through its full range.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int WORD_W = 12;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int CUST_W = 3 * BYTE_W;

  localparam int SHORT_N   = 9;
  localparam int SHORT_TAP = 5;
  localparam int LONG_N    = 23;
  localparam int LONG_TAP  = 18;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_FMT   = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_LVL   = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_CUST0 = 4'h7;
  localparam logic [ADDR_W-1:0] ADDR_CUST1 = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_CUST2 = 4'h9;

  localparam logic [2:0] PAT_SKEW = 3'd0;
  localparam logic [2:0] PAT_SYNC = 3'd1;
  localparam logic [2:0] PAT_CUST = 3'd2;
  localparam logic [2:0] PAT_RAMP = 3'd3;
  localparam logic [2:0] PAT_PN_S = 3'd4;
  localparam logic [2:0] PAT_PN_L = 3'd5;

  localparam logic [WORD_W-1:0] SKEW_WORD = 12'h555;
  localparam logic [WORD_W-1:0] SYNC_WORD = 12'hFC0;

  typedef struct packed {
    logic              test_en;
    logic [2:0]        pat_sel;
    logic              twos;
    logic              msb_first;
    logic [1:0]        lvl_data;
    logic [1:0]        lvl_frame;
    logic [1:0]        lvl_clk;
    logic [CUST_W-1:0] cust;
  } cfg_t;

  // lvl[1] set: static level lvl[0]; else pass running value
  function automatic logic lvl_apply(input logic [1:0] lvl, input logic raw);
    return lvl[1] ? lvl[0] : raw;
  endfunction
endpackage

// File: rtl/adc_fmt_regs.sv
module adc_fmt_regs
  import adc_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_MODE: begin
          cfg_q.test_en <= wr_data_i[0];
          cfg_q.pat_sel <= wr_data_i[3:1];
        end
        ADDR_FMT: begin
          cfg_q.twos      <= wr_data_i[0];
          cfg_q.msb_first <= wr_data_i[1];
        end
        ADDR_LVL: begin
          cfg_q.lvl_data  <= wr_data_i[1:0];
          cfg_q.lvl_frame <= wr_data_i[3:2];
          cfg_q.lvl_clk   <= wr_data_i[5:4];
        end
        ADDR_CUST0: cfg_q.cust[3*BYTE_W-1:2*BYTE_W] <= wr_data_i;
        ADDR_CUST1: cfg_q.cust[2*BYTE_W-1:BYTE_W]   <= wr_data_i;
        ADDR_CUST2: cfg_q.cust[BYTE_W-1:0]          <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/adc_fmt_lfsr.sv
module adc_fmt_lfsr #(
  parameter int N   = 9,
  parameter int TAP = 5,
  parameter int W   = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         step_i,
  output logic [W-1:0] word_o
);
  logic [N-1:0] st_q, st_d;
  logic [W-1:0] w;

  // W serial steps per frame, first new bit lands in word bit 0
  always_comb begin
    st_d = st_q;
    w    = '0;
    for (int i = 0; i < W; i++) begin
      w[i] = st_d[N-1] ^ st_d[TAP-1];
      st_d = {st_d[N-2:0], w[i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '1;
    else if (hold_i) st_q <= '1;
    else if (step_i) st_q <= st_d;
  end

  assign word_o = w;
endmodule

// File: rtl/adc_fmt_patgen.sv
module adc_fmt_patgen
  import adc_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              load_i,
  input  logic [2:0]        pat_sel_i,
  input  logic [CUST_W-1:0] cust_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] ramp_q;
  logic              odd_q;
  logic [WORD_W-1:0] pn_s, pn_l;
  logic              step;

  assign step = test_en_i & load_i;

  adc_fmt_lfsr #(.N(SHORT_N), .TAP(SHORT_TAP), .W(WORD_W)) u_pn_short (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (!test_en_i),
    .step_i (step),
    .word_o (pn_s)
  );

  adc_fmt_lfsr #(.N(LONG_N), .TAP(LONG_TAP), .W(WORD_W)) u_pn_long (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (!test_en_i),
    .step_i (step),
    .word_o (pn_l)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      odd_q  <= 1'b0;
    end else if (!test_en_i) begin
      ramp_q <= '0;
      odd_q  <= 1'b0;
    end else if (load_i) begin
      ramp_q <= ramp_q + WORD_W'(1);
      odd_q  <= ~odd_q;
    end
  end

  always_comb begin
    case (pat_sel_i)
      PAT_SKEW: word_o = SKEW_WORD;
      PAT_SYNC: word_o = SYNC_WORD;
      PAT_CUST: word_o = odd_q ? cust_i[WORD_W-1:0] : cust_i[2*WORD_W-1:WORD_W];
      PAT_RAMP: word_o = ramp_q;
      PAT_PN_S: word_o = pn_s;
      PAT_PN_L: word_o = pn_l;
      default:  word_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_fmt_lane.sv
module adc_fmt_lane
  import adc_fmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              twos_i,
  input  logic              msb_first_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] coded, ordered, sh_q;

  assign coded = {word_i[WORD_W-1] ^ twos_i, word_i[WORD_W-2:0]};

  for (genvar i = 0; i < WORD_W; i++) begin : g_ord
    assign ordered[i] = msb_first_i ? coded[WORD_W-1-i] : coded[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= ordered;
    else             sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/adc_pattern_fmt.sv
module adc_pattern_fmt
  import adc_fmt_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic [NUM_CH*WORD_W-1:0] sample_i,
  output logic [NUM_CH-1:0]        ser_o,
  output logic                     frame_o,
  output logic                     dclk_o
);
  cfg_t              cfg;
  logic              test_en;
  logic [1:0]        lvl_data, lvl_frame, lvl_clk;
  logic [CNT_W-1:0]  slot_q;
  logic              load;
  logic [WORD_W-1:0] test_word;
  logic [NUM_CH-1:0] lane_bit;

  adc_fmt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  assign test_en   = cfg.test_en;
  assign lvl_data  = cfg.lvl_data;
  assign lvl_frame = cfg.lvl_frame;
  assign lvl_clk   = cfg.lvl_clk;

  assign load = (slot_q == CNT_W'(WORD_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   slot_q <= '0;
    else if (load) slot_q <= '0;
    else           slot_q <= slot_q + CNT_W'(1);
  end

  adc_fmt_patgen u_patgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .test_en_i (test_en),
    .load_i    (load),
    .pat_sel_i (cfg.pat_sel),
    .cust_i    (cfg.cust),
    .word_o    (test_word)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [WORD_W-1:0] src;
    assign src = test_en ? test_word : sample_i[c*WORD_W +: WORD_W];

    adc_fmt_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .word_i      (src),
      .twos_i      (cfg.twos),
      .msb_first_i (cfg.msb_first),
      .bit_o       (lane_bit[c])
    );

    // data level override is a normal-mode feature only
    assign ser_o[c] = test_en ? lane_bit[c] : lvl_apply(lvl_data, lane_bit[c]);
  end

  assign frame_o = lvl_apply(lvl_frame, slot_q < CNT_W'(WORD_W/2));
  assign dclk_o  = lvl_apply(lvl_clk, ~slot_q[0]);
endmodule

// File: rtl/adc_pattern_fmt_chk.sv
module adc_pattern_fmt_chk
  import adc_fmt_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  slot_i,
  input logic              load_i,
  input logic              test_en_i,
  input logic [1:0]        lvl_data_i,
  input logic [1:0]        lvl_frame_i,
  input logic [1:0]        lvl_clk_i,
  input logic [NUM_CH-1:0] ser_i,
  input logic              frame_i,
  input logic              dclk_i
);
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (slot_i == '0)); // R2

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (slot_i == CNT_W'($past(slot_i) + CNT_W'(1)))); // R2

  AST_FRAME_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_frame_i[1] && slot_i == '0) |-> frame_i); // R1

  AST_FRAME_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_frame_i[1] && slot_i == CNT_W'(WORD_W/2)) |-> !frame_i); // R1

  AST_DCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_clk_i[1] |=> (lvl_clk_i[1] || dclk_i != $past(dclk_i))); // R1

  AST_FRAME_STATIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_frame_i[1] && $stable(lvl_frame_i)) |-> $stable(frame_i)); // R12

  AST_DCLK_STATIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_clk_i[1] && $stable(lvl_clk_i)) |-> $stable(dclk_i)); // R12

  AST_DATA_STATIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_en_i && lvl_data_i[1] && $stable({test_en_i, lvl_data_i})) |-> $stable(ser_i)); // R11
endmodule

bind adc_pattern_fmt adc_pattern_fmt_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_i      (slot_q),
  .load_i      (load),
  .test_en_i   (test_en),
  .lvl_data_i  (lvl_data),
  .lvl_frame_i (lvl_frame),
  .lvl_clk_i   (lvl_clk),
  .ser_i       (ser_o),
  .frame_i     (frame_o),
  .dclk_i      (dclk_o)
);

// File: tb/adc_pattern_fmt_tb.sv
module adc_pattern_fmt_tb;
  localparam int NCH = 8;
  localparam int W   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NCH*W-1:0] sample = '0;
  logic [NCH-1:0] ser;
  logic frame, dclk;

  int n_chk = 0;
  int n_fail = 0;
  int unsigned cyc = 0;

  logic [NCH-1:0][W-1:0] cap;
  logic [W-1:0] cap_frame, cap_dclk;

  always #10 clk = ~clk;

  adc_pattern_fmt #(.NUM_CH(NCH)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .sample_i  (sample),
    .ser_o     (ser),
    .frame_o   (frame),
    .dclk_o    (dclk)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // next full frame whose word was loaded after the caller's last action
  task automatic get_frame();
    @(negedge clk);
    while (cyc % W != 0) @(negedge clk);
    for (int b = 0; b < W; b++) begin
      if (b > 0) @(negedge clk);
      for (int c = 0; c < NCH; c++) cap[c][b] = ser[c];
      cap_frame[b] = frame;
      cap_dclk[b]  = dclk;
    end
  endtask

  function automatic logic [W-1:0] ser_of(input logic [W-1:0] wd, input logic twos, input logic msb);
    logic [W-1:0] cd, r;
    cd = wd ^ (W'(twos) << (W-1));
    for (int i = 0; i < W; i++) r[i] = msb ? cd[W-1-i] : cd[i];
    return r;
  endfunction

  function automatic logic [W-1:0] pn_word(inout logic [22:0] s, input int n, input int tap);
    logic [23:0] one;
    logic [22:0] mask;
    logic [W-1:0] w;
    logic nb;
    one = 24'd1 << n;
    mask = 23'(one - 24'd1);
    for (int i = 0; i < W; i++) begin
      nb = s[n-1] ^ s[tap-1];
      w[i] = nb;
      s = ((s << 1) | 23'(nb)) & mask;
    end
    return w;
  endfunction

  task automatic chk_all(input string req, input string what, input logic [W-1:0] exp);
    int bad = -1;
    for (int c = 0; c < NCH; c++) if (cap[c] !== exp && bad < 0) bad = c;
    chk(bad < 0, req, what, (bad < 0) ? 32'(cap[0]) : 32'(cap[bad]), 32'(exp));
  endtask

  task automatic chk_samples(input string req, input string what, input logic twos, input logic msb);
    int bad = -1;
    logic [W-1:0] e;
    for (int c = 0; c < NCH; c++) begin
      e = ser_of(sample[c*W +: W], twos, msb);
      if (cap[c] !== e && bad < 0) bad = c;
    end
    if (bad < 0) bad = 0;
    e = ser_of(sample[bad*W +: W], twos, msb);
    chk(cap[bad] === e, req, what, 32'(cap[bad]), 32'(e));
  endtask

  task automatic set_samples(input int seed);
    for (int c = 0; c < NCH; c++) sample[c*W +: W] = W'(c * 'h1F3 + seed);
  endtask

  task automatic t_reset();
    chk(ser === '0, "R1", "lanes in reset", 32'(ser), 0);
    chk(frame === 1'b1 && dclk === 1'b1, "R1", "markers in reset", {frame, dclk}, 2'b11);
    @(negedge clk); rst_n = 1'b1;
    get_frame();
    chk_all("R1", "first frame zero", '0);
    chk(cap_frame === 12'h03F, "R1", "frame marker shape", 32'(cap_frame), 32'h03F);
    chk(cap_dclk === 12'h555, "R1", "bit clock shape", 32'(cap_dclk), 32'h555);
  endtask

  task automatic t_normal();
    set_samples('h02A);
    wr(4'h1, {4'b0, 3'd1, 1'b0});      // sync selected, test off: no effect
    get_frame();
    chk_samples("R2", "live samples A", 1'b0, 1'b0);
    set_samples('h9C7);
    get_frame();
    chk_samples("R2", "live samples B", 1'b0, 1'b0);
    wr(4'h5, 8'hFF);                   // unused address ignored
    get_frame();
    chk_samples("R3", "unmapped write ignored", 1'b0, 1'b0);
  endtask

  task automatic t_format();
    wr(4'h2, 8'h01);
    get_frame();
    chk_samples("R9", "two's complement", 1'b1, 1'b0);
    wr(4'h2, 8'h02);
    get_frame();
    chk_samples("R10", "msb first", 1'b0, 1'b1);
    wr(4'h2, 8'h03);
    get_frame();
    chk_samples("R10", "msb first with R9 coding", 1'b1, 1'b1);
    wr(4'h2, 8'h00);
  endtask

  task automatic t_data_force();
    wr(4'h3, 8'h03);
    get_frame();
    chk_all("R11", "forced high", 12'hFFF);
    wr(4'h3, 8'h02);
    get_frame();
    chk_all("R11", "forced low", 12'h000);
    wr(4'h3, 8'h03);
    wr(4'h1, {4'b0, 3'd0, 1'b1});
    get_frame();
    chk_all("R11", "override ignored in test mode", 12'h555);
    wr(4'h1, 8'h00);
    wr(4'h3, 8'h00);
  endtask

  task automatic t_marker_force();
    wr(4'h3, 8'h2C);                   // frame high, clock low
    get_frame();
    chk(cap_frame === 12'hFFF, "R12", "frame forced high", 32'(cap_frame), 32'hFFF);
    chk(cap_dclk === 12'h000, "R12", "clock forced low", 32'(cap_dclk), 0);
    wr(4'h3, 8'h38);                   // frame low, clock high
    get_frame();
    chk(cap_frame === 12'h000 && cap_dclk === 12'hFFF, "R12", "frame low clock high",
        32'({cap_frame, cap_dclk}), 32'h000FFF);
    wr(4'h3, 8'h00);
  endtask

  task automatic t_skew_sync();
    wr(4'h1, {4'b0, 3'd0, 1'b1});
    get_frame(); chk_all("R4", "skew frame 0", 12'h555);
    get_frame(); chk_all("R4", "skew frame 1", 12'h555);
    wr(4'h1, {4'b0, 3'd1, 1'b1});
    get_frame(); chk_all("R4", "sync frame 0", ser_of(12'hFC0, 1'b0, 1'b0));
    get_frame(); chk_all("R4", "sync frame 1", ser_of(12'hFC0, 1'b0, 1'b0));
    wr(4'h1, 8'h00);
  endtask

  task automatic t_custom();
    wr(4'h7, 8'hA5);
    wr(4'h8, 8'h3C);
    wr(4'h9, 8'h81);
    wr(4'h1, {4'b0, 3'd2, 1'b1});
    get_frame(); chk_all("R5", "custom even 0", 12'hA53);
    get_frame(); chk_all("R5", "custom odd", 12'hC81);
    get_frame(); chk_all("R5", "custom even 1", 12'hA53);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_ramp();
    int bad = 0;
    logic [W-1:0] first_bad_act = '0, first_bad_exp = '0;
    wr(4'h1, {4'b0, 3'd3, 1'b1});
    for (int k = 0; k < 4098; k++) begin
      get_frame();
      if (k == 0) chk_all("R6", "ramp starts at 0", 12'd0);
      if (k == 4095) chk_all("R6", "ramp top", 12'd4095);
      if (k == 4096) chk_all("R6", "ramp wrap", 12'd0);
      if (cap[0] !== W'(k) && bad == 0) begin
        first_bad_act = cap[0]; first_bad_exp = W'(k);
      end
      if (cap[0] !== W'(k)) bad++;
    end
    chk(bad == 0, "R6", "ramp sequence", 32'(first_bad_act), 32'(first_bad_exp));
    wr(4'h1, 8'h00);
  endtask

  task automatic t_pn();
    logic [22:0] s;
    logic [W-1:0] e;
    s = 23'h1FF;
    wr(4'h1, {4'b0, 3'd4, 1'b1});
    for (int k = 0; k < 4; k++) begin
      e = pn_word(s, 9, 5);
      get_frame();
      chk_all("R7", "short sequence", e);
    end
    wr(4'h1, 8'h00);
    s = 23'h7FFFFF;
    wr(4'h1, {4'b0, 3'd5, 1'b1});
    for (int k = 0; k < 4; k++) begin
      e = pn_word(s, 23, 18);
      get_frame();
      chk_all("R8", "long sequence", e);
    end
    wr(4'h1, 8'h00);
    // frames 0..2 show skew; sequence keeps stepping, frame 3 shows word 3
    s = 23'h1FF;
    wr(4'h1, {4'b0, 3'd0, 1'b1});
    get_frame(); get_frame();
    wr(4'h1, {4'b0, 3'd4, 1'b1});
    get_frame();
    for (int k = 0; k < 4; k++) e = pn_word(s, 9, 5);
    chk_all("R7", "sequence advances under other pattern", e);
    wr(4'h1, 8'h00);
  endtask

  task automatic t_undef();
    wr(4'h1, {4'b0, 3'd6, 1'b1});
    get_frame(); chk_all("R13", "select 6 zero", 12'h000);
    wr(4'h1, {4'b0, 3'd7, 1'b1});
    get_frame(); chk_all("R13", "select 7 zero", 12'h000);
    wr(4'h1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_format();
    t_data_force();
    t_marker_force();
    t_skew_sync();
    t_custom();
    t_ramp();
    t_pn();
    t_undef();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL all watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule